// File: doc/BRIEF.md
# Interlock Trip Decision and Masking

This block sits in the master node of a machine protection chain. Once per status interval, nominally every 1 µs, the acquisition chain delivers a wide word of interlock status bits with a valid strobe. Each bit is active-low: a 0 means that input reports a fault. The block forms a trip whenever any faulting bit is not suppressed by its mask bit. A trip drives every beam-cutoff output from low to high. It then holds them there until an explicit clear command is accepted.

On the first trip the block also freezes a snapshot of the faulting status word and the timestamp presented with it, so software can read it out later. The mask is loaded through a narrow write-only register port, one word per address. It lets operators silence inputs known to give false triggers. The decision path is one register deep, so the block's share of the shut-off budget is a single clock cycle.

Top module: `trip_guard`

## Requirements
- R1: After reset all cutoff outputs are low, rec_valid_o is low, rec_status_o and rec_time_o are zero, and every mask bit is cleared, so no input is suppressed.
- R2: A status word accepted with status_valid_i high that has any bit at 0 whose mask bit is 0 drives all N_OUT cutoff outputs high at the first rising clock edge. The outputs are therefore visible one cycle later, and they are always all equal.
- R3: status_n_i is ignored while status_valid_i is low: no trip and no record capture happen, whatever the word holds.
- R4: A mask bit at 1 suppresses the status bit of the same index. Mask write address k loads mask_wdata_i into status bits [k*REG_W +: REG_W]. A word whose only zero bits are masked causes no trip.
- R5: Once tripped, the cutoff outputs stay high through any number of later fault-free words until a clear is accepted.
- R6: trip_clr_i clears the cutoff outputs at the next edge, but only under two conditions. The last status word accepted before that cycle must show no unmasked fault under the current mask. Any word accepted in the same cycle must also be clean. If either condition fails, the clear is refused and the outputs stay high.
- R7: On a trip with no record held, rec_status_o and rec_time_o take the tripping word and time_i at that edge, and rec_valid_o goes high.
- R8: While rec_valid_o is high, later trips leave the record unchanged. rec_clr_i empties the record to zeros. A trip in the same cycle as rec_clr_i is captured as the new record.
- R9: A trip and trip_clr_i in the same cycle leave the cutoff outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_valid_i | input | 1 | Status word strobe |
| status_n_i | input | N_IN | Interlock status, 0 = fault |
| time_i | input | TS_W | Current timestamp |
| mask_we_i | input | 1 | Mask word write enable |
| mask_addr_i | input | AW | Mask word index |
| mask_wdata_i | input | REG_W | Mask word data, 1 = suppress |
| trip_clr_i | input | 1 | Request to release the cutoff outputs |
| rec_clr_i | input | 1 | Empty the fault record |
| cutoff_o | output | N_OUT | Beam-cutoff outputs, high = cut |
| rec_valid_o | output | 1 | Fault record holds a snapshot |
| rec_status_o | output | N_IN | Captured status word |
| rec_time_o | output | TS_W | Captured timestamp |

## Verification
Two pairs of functions can collide in one cycle. A faulting word can arrive while trip_clr_i is asserted, and a new trip can arrive while rec_clr_i empties the record. The bench drives both coincidences from the same negative edge. It then judges them at the next one: the cutoff outputs must stay high, and the record must hold the newer word and timestamp, not zeros and not the older snapshot. A clear refused because of a held fault is also shown to be accepted once the mask covers that fault.

// File: rtl/trip_pkg.sv
`timescale 1ns/1ps
package trip_pkg;
  localparam int unsigned DEF_N_IN  = 64;
  localparam int unsigned DEF_N_OUT = 24;
  localparam int unsigned DEF_TS_W  = 64;
  localparam int unsigned DEF_REG_W = 32;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned addr_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/trip_mask_regs.sv
`timescale 1ns/1ps
module trip_mask_regs #(
  parameter int unsigned N_IN    = 64,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned N_WORDS = trip_pkg::ceil_div(N_IN, REG_W),
  parameter int unsigned AW      = trip_pkg::addr_bits(N_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [N_IN-1:0]  mask_o
);
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam int unsigned LO = k * REG_W;
    localparam int unsigned W  = ((N_IN - LO) < REG_W) ? (N_IN - LO) : REG_W;
    logic [W-1:0] word_q;
    logic         hit;
    assign hit = we_i && (addr_i == AW'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= wdata_i[W-1:0];
    end
    assign mask_o[LO +: W] = word_q;
  end
endmodule

// File: rtl/trip_detect.sv
`timescale 1ns/1ps
module trip_detect #(
  parameter int unsigned N_IN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [N_IN-1:0] status_n_i,
  input  logic [N_IN-1:0] mask_i,
  output logic            trip_evt_o,
  output logic            live_fault_o
);
  logic [N_IN-1:0] last_q;
  logic [N_IN-1:0] new_hits;
  logic [N_IN-1:0] old_hits;

  assign new_hits     = ~status_n_i & ~mask_i;
  assign old_hits     = ~last_q & ~mask_i;
  assign trip_evt_o   = valid_i && (|new_hits);
  assign live_fault_o = |old_hits;

  // last accepted word; all ones = healthy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= '1;
    else if (valid_i) last_q <= status_n_i;
  end
endmodule

// File: rtl/trip_latch.sv
`timescale 1ns/1ps
module trip_latch #(
  parameter int unsigned N_OUT = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trip_evt_i,
  input  logic             live_fault_i,
  input  logic             clr_req_i,
  output logic [N_OUT-1:0] cutoff_o
);
  logic clr_ok;
  assign clr_ok = clr_req_i && !trip_evt_i && !live_fault_i;

  // one flop per channel, no shared output register
  for (genvar c = 0; c < N_OUT; c++) begin : g_chan
    logic chan_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         chan_q <= 1'b0;
      else if (trip_evt_i) chan_q <= 1'b1;
      else if (clr_ok)     chan_q <= 1'b0;
    end
    assign cutoff_o[c] = chan_q;
  end
endmodule

// File: rtl/trip_record.sv
`timescale 1ns/1ps
module trip_record #(
  parameter int unsigned N_IN = 64,
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trip_evt_i,
  input  logic            clr_i,
  input  logic [N_IN-1:0] status_n_i,
  input  logic [TS_W-1:0] time_i,
  output logic            valid_o,
  output logic [N_IN-1:0] status_o,
  output logic [TS_W-1:0] time_o
);
  logic take;
  assign take = trip_evt_i && (!valid_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      status_o <= '0;
      time_o   <= '0;
    end else if (take) begin
      valid_o  <= 1'b1;
      status_o <= status_n_i;
      time_o   <= time_i;
    end else if (clr_i) begin
      valid_o  <= 1'b0;
      status_o <= '0;
      time_o   <= '0;
    end
  end
endmodule

// File: rtl/trip_guard.sv
`timescale 1ns/1ps
module trip_guard #(
  parameter int unsigned N_IN  = trip_pkg::DEF_N_IN,
  parameter int unsigned N_OUT = trip_pkg::DEF_N_OUT,
  parameter int unsigned TS_W  = trip_pkg::DEF_TS_W,
  parameter int unsigned REG_W = trip_pkg::DEF_REG_W,
  localparam int unsigned N_WORDS = trip_pkg::ceil_div(N_IN, REG_W),
  localparam int unsigned AW      = trip_pkg::addr_bits(N_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             status_valid_i,
  input  logic [N_IN-1:0]  status_n_i,
  input  logic [TS_W-1:0]  time_i,
  input  logic             mask_we_i,
  input  logic [AW-1:0]    mask_addr_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  input  logic             trip_clr_i,
  input  logic             rec_clr_i,
  output logic [N_OUT-1:0] cutoff_o,
  output logic             rec_valid_o,
  output logic [N_IN-1:0]  rec_status_o,
  output logic [TS_W-1:0]  rec_time_o
);
  logic [N_IN-1:0] mask_w;
  logic            trip_evt;
  logic            live_fault;

  trip_mask_regs #(.N_IN(N_IN), .REG_W(REG_W), .N_WORDS(N_WORDS), .AW(AW)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .addr_i  (mask_addr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_w)
  );

  trip_detect #(.N_IN(N_IN)) u_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (status_valid_i),
    .status_n_i   (status_n_i),
    .mask_i       (mask_w),
    .trip_evt_o   (trip_evt),
    .live_fault_o (live_fault)
  );

  trip_latch #(.N_OUT(N_OUT)) u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trip_evt_i   (trip_evt),
    .live_fault_i (live_fault),
    .clr_req_i    (trip_clr_i),
    .cutoff_o     (cutoff_o)
  );

  trip_record #(.N_IN(N_IN), .TS_W(TS_W)) u_record (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_evt_i (trip_evt),
    .clr_i      (rec_clr_i),
    .status_n_i (status_n_i),
    .time_i     (time_i),
    .valid_o    (rec_valid_o),
    .status_o   (rec_status_o),
    .time_o     (rec_time_o)
  );
endmodule

// File: rtl/trip_guard_chk.sv
`timescale 1ns/1ps
module trip_guard_chk #(
  parameter int unsigned N_IN  = 64,
  parameter int unsigned N_OUT = 24,
  parameter int unsigned TS_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             status_valid_i,
  input logic [N_IN-1:0]  status_n_i,
  input logic [N_IN-1:0]  mask_i,
  input logic             trip_clr_i,
  input logic             rec_clr_i,
  input logic [N_OUT-1:0] cutoff_o,
  input logic             rec_valid_o,
  input logic [N_IN-1:0]  rec_status_o,
  input logic [TS_W-1:0]  rec_time_o
);
  logic [N_IN-1:0] shadow_q;
  logic            fault_now;
  logic            held_fault;
  logic            all_hi;
  logic            all_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             shadow_q <= '1;
    else if (status_valid_i) shadow_q <= status_n_i;
  end

  assign fault_now  = status_valid_i && ((~status_n_i & ~mask_i) != '0);
  assign held_fault = (~shadow_q & ~mask_i) != '0;
  assign all_hi     = &cutoff_o;
  assign all_lo     = (cutoff_o == '0);

  AST_OUTS_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_hi || all_lo);  // R2
  AST_TRIP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_now |=> all_hi);  // R2
  AST_NO_STROBE_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_valid_i && all_lo) |=> all_lo);  // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_hi && !trip_clr_i) |=> all_hi);  // R5
  AST_CLR_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_hi && trip_clr_i && held_fault) |=> all_hi);  // R6
  AST_CLR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_clr_i && !fault_now && !held_fault) |=> all_lo);  // R6
  AST_REC_WITH_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_valid_o) |-> all_hi);  // R7
  AST_REC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_clr_i) |=> ($stable(rec_status_o) && $stable(rec_time_o) && rec_valid_o));  // R8
  AST_TRIP_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_now && trip_clr_i) |=> all_hi);  // R9
endmodule

bind trip_guard trip_guard_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .TS_W(TS_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .status_valid_i (status_valid_i),
  .status_n_i     (status_n_i),
  .mask_i         (mask_w),
  .trip_clr_i     (trip_clr_i),
  .rec_clr_i      (rec_clr_i),
  .cutoff_o       (cutoff_o),
  .rec_valid_o    (rec_valid_o),
  .rec_status_o   (rec_status_o),
  .rec_time_o     (rec_time_o)
);

// File: tb/trip_guard_bench.sv
`timescale 1ns/1ps
module trip_guard_bench;
  localparam int unsigned N_IN  = 64;
  localparam int unsigned N_OUT = 24;
  localparam int unsigned TS_W  = 64;
  localparam int unsigned REG_W = 32;
  localparam logic [N_IN-1:0]  CLEAN = '1;
  localparam logic [N_OUT-1:0] CUT   = '1;

  typedef struct packed {
    logic [N_IN-1:0] word;
    logic            trip;
  } vec_t;

  // mask used by the table: word0 = 0xF0 (bits 7:4), word1 = 0x8000_0000 (bit 63)
  localparam vec_t VECS [8] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFE, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFDF, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 1'b0},
    '{64'hBFFF_FFFF_FFFF_FFFF, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FF0F, 1'b0},
    '{64'hFFFF_FEFF_FFFF_FFEF, 1'b1},
    '{64'h0000_0000_0000_0000, 1'b1}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             status_valid_i = 1'b0;
  logic [N_IN-1:0]  status_n_i = '1;
  logic [TS_W-1:0]  time_i = '0;
  logic             mask_we_i = 1'b0;
  logic [0:0]       mask_addr_i = '0;
  logic [REG_W-1:0] mask_wdata_i = '0;
  logic             trip_clr_i = 1'b0;
  logic             rec_clr_i = 1'b0;
  logic [N_OUT-1:0] cutoff_o;
  logic             rec_valid_o;
  logic [N_IN-1:0]  rec_status_o;
  logic [TS_W-1:0]  rec_time_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  trip_guard #(.N_IN(N_IN), .N_OUT(N_OUT), .TS_W(TS_W), .REG_W(REG_W)) u_trip_guard (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [N_IN-1:0] w, input logic [TS_W-1:0] t);
    status_n_i = w; time_i = t; status_valid_i = 1'b1;
    @(negedge clk_i);
    status_valid_i = 1'b0; status_n_i = CLEAN;
  endtask

  task automatic pulse(input bit tc, input bit rc);
    trip_clr_i = tc; rec_clr_i = rc;
    @(negedge clk_i);
    trip_clr_i = 1'b0; rec_clr_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [0:0] a, input logic [REG_W-1:0] d);
    mask_we_i = 1'b1; mask_addr_i = a; mask_wdata_i = d;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  task automatic cleanup;
    send(CLEAN, '0);
    pulse(1'b1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cutoff_o == '0, "R1 cutoff", 64'(cutoff_o), 64'h0);
    chk(!rec_valid_o, "R1 rec_valid", 64'(rec_valid_o), 64'h0);
    chk(rec_status_o == '0 && rec_time_o == '0, "R1 record", rec_time_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 mask cleared: bit 5 trips
    send(64'hFFFF_FFFF_FFFF_FFDF, 64'd7);
    chk(cutoff_o == CUT, "R1 mask clear", 64'(cutoff_o), 64'(CUT));
    cleanup();
    chk(cutoff_o == '0 && !rec_valid_o, "R1 cleanup", 64'(cutoff_o), 64'h0);

    // R3 word without strobe
    status_n_i = '0;
    repeat (3) @(negedge clk_i);
    status_n_i = CLEAN;
    chk(cutoff_o == '0, "R3 no strobe cutoff", 64'(cutoff_o), 64'h0);
    chk(!rec_valid_o, "R3 no strobe record", 64'(rec_valid_o), 64'h0);

    wr_mask(1'b0, 32'h0000_00F0);
    wr_mask(1'b1, 32'h8000_0000);

    // R2 R4 R7 table
    for (int i = 0; i < 8; i++) begin
      cleanup();
      send(VECS[i].word, 64'd1000 + 64'(i));
      chk(cutoff_o == (VECS[i].trip ? CUT : '0), $sformatf("R2 R4 vec%0d cutoff", i),
          64'(cutoff_o), VECS[i].trip ? 64'(CUT) : 64'h0);
      chk(rec_valid_o == VECS[i].trip, $sformatf("R7 vec%0d valid", i), 64'(rec_valid_o), 64'(VECS[i].trip));
      chk(rec_status_o == (VECS[i].trip ? VECS[i].word : '0), $sformatf("R7 vec%0d word", i),
          rec_status_o, VECS[i].trip ? VECS[i].word : 64'h0);
      chk(rec_time_o == (VECS[i].trip ? 64'd1000 + 64'(i) : '0), $sformatf("R7 vec%0d time", i),
          rec_time_o, VECS[i].trip ? 64'd1000 + 64'(i) : 64'h0);
    end

    // R5 latch hold
    cleanup();
    send(64'hFFFF_FFFF_FFFF_FFFE, 64'd100);
    repeat (3) send(CLEAN, 64'd101);
    chk(cutoff_o == CUT, "R5 hold", 64'(cutoff_o), 64'(CUT));
    // R8 second trip does not overwrite
    send(64'hFFFF_FFFF_FFFF_FFFD, 64'd200);
    chk(rec_time_o == 64'd100, "R8 first kept time", rec_time_o, 64'd100);
    chk(rec_status_o == 64'hFFFF_FFFF_FFFF_FFFE, "R8 first kept word", rec_status_o, 64'hFFFF_FFFF_FFFF_FFFE);

    // R6 refused while held fault (bit 1) unmasked
    pulse(1'b1, 1'b0);
    chk(cutoff_o == CUT, "R6 refused", 64'(cutoff_o), 64'(CUT));
    wr_mask(1'b0, 32'h0000_00F2);
    pulse(1'b1, 1'b0);
    chk(cutoff_o == '0, "R6 accepted after mask", 64'(cutoff_o), 64'h0);
    wr_mask(1'b0, 32'h0000_00F0);

    // R8 clear record
    pulse(1'b0, 1'b1);
    chk(!rec_valid_o && rec_time_o == '0, "R8 cleared", rec_time_o, 64'h0);

    // R8 clear with a trip in the same cycle
    send(64'hFFFF_FFFF_FFFF_FFFB, 64'd250);
    status_n_i = 64'hFFFF_FFFF_FFFF_FFF7; time_i = 64'd300;
    status_valid_i = 1'b1; rec_clr_i = 1'b1;
    @(negedge clk_i);
    status_valid_i = 1'b0; rec_clr_i = 1'b0; status_n_i = CLEAN;
    chk(rec_valid_o && rec_time_o == 64'd300, "R8 clear+trip time", rec_time_o, 64'd300);
    chk(rec_status_o == 64'hFFFF_FFFF_FFFF_FFF7, "R8 clear+trip word", rec_status_o, 64'hFFFF_FFFF_FFFF_FFF7);

    // R9 trip with clear in the same cycle
    cleanup();
    chk(cutoff_o == '0, "R9 pre", 64'(cutoff_o), 64'h0);
    status_n_i = 64'hEFFF_FFFF_FFFF_FFFF; time_i = 64'd400;
    status_valid_i = 1'b1; trip_clr_i = 1'b1;
    @(negedge clk_i);
    status_valid_i = 1'b0; trip_clr_i = 1'b0; status_n_i = CLEAN;
    chk(cutoff_o == CUT, "R9 trip wins", 64'(cutoff_o), 64'(CUT));

    // R6 clean word then clear
    send(CLEAN, 64'd401);
    pulse(1'b1, 1'b0);
    chk(cutoff_o == '0, "R6 clean clear", 64'(cutoff_o), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule